// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block keeps the receive and transmit statistics of one Ethernet port. The MAC datapath sends it one strobe per finished frame. The strobe carries the frame length, a direction bit and a byte of classification flags. From each strobe the block advances a total frame counter, one length bin and any flagged class counters. For receive frames longer than a programmable limit it also advances a separate counter. A per-direction byte counter adds the frame length.

Software reads the counters through a simple read port. Each read returns the counter's value one cycle later and clears that counter in the same cycle. The byte counters are wider than the 32-bit read word, so each is read as a low word followed by a high word. Reading the low word copies the upper bits into a shadow register, so the two halves always belong to the same snapshot. A clear-all input zeroes every counter and both shadows at once. An event that arrives in the same cycle as a clear is counted into the fresh value. Every counter holds at its maximum value instead of wrapping.

Top module: `stats_bank`

## Requirements
- R1: A receive event (`ev_valid`=1, `ev_dir`=0) adds one to the receive total at address 0. It also adds one to exactly one receive length bin at addresses 10 to 16, chosen by `ev_len`: up to 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 or more.
- R2: On a receive event, each set bit i of `ev_flags` adds one to the counter at address 1+i. The bits are: 0 multicast, 1 broadcast, 2 FCS error, 3 pause, 4 jabber, 5 short, 6 symbol-code error, 7 oversize.
- R3: A receive event with `ev_len` greater than `cfg_max_len` adds one to the counter at address 9. Transmit events never touch it.
- R4: A transmit event (`ev_dir`=1) adds one to the transmit total at address 17 and to the transmit length bin at addresses 22 to 28, using the same bin limits as R1. Flag bits 0 to 3 count at addresses 18 (multicast), 19 (broadcast), 20 (error frame) and 21 (pause). Flag bits 4 to 7 are ignored.
- R5: The receive and transmit byte counters are BYTE_W bits wide (45 by default) and add `ev_len` per event of their direction. Address 32 (receive) or 34 (transmit) returns bits 31:0 and latches the upper bits into a shadow. Address 33 or 35 returns that shadow, zero-extended.
- R6: `rd_en` with `rd_addr` returns the value in `rd_data` one cycle later, as the value was before that cycle. The read clears the addressed counter. A read of a high-word address clears nothing.
- R7: An event in the same cycle as a clearing read of a counter it advances leaves that counter at the event's increment, not at zero.
- R8: `clr_all` zeroes every counter and both shadows. An event in the same cycle is counted into the zeroed value.
- R9: Frame counters (FRAME_W bits, 32 by default) and byte counters stop at their all-ones value and do not wrap.
- R10: `rd_valid` is high exactly one cycle after each `rd_en`. Unmapped addresses (29–31 and 36–63) read as zero.
- R11: After reset every counter and shadow reads as zero and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Frame-done strobe |
| ev_dir | input | 1 | 0 receive, 1 transmit |
| ev_len | input | LEN_W | Frame length in bytes |
| ev_flags | input | 8 | Classification flags |
| cfg_max_len | input | LEN_W | Receive maximum packet size |
| clr_all | input | 1 | Clear every counter |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Counter address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Random receive and transmit events mix lengths drawn from the bin edges (63/64/65 up to 1518/1519) with arbitrary lengths and flag bytes. Random reads, including the unmapped addresses, are interleaved with the events, and clear-all pulses are rare. These runs separate bin selection errors, flag-to-counter mapping errors and direction mix-ups.

Directed cases cover several same-cycle situations that only show up in timing:
- a read coinciding with an event, which tells a lost increment from a correct fresh count;
- clear-all coinciding with an event;
- a lowered maximum size, tested one byte below and one byte above it;
- enough huge transmit frames to fill the byte counter's upper word, which checks the shadowed high read;
- a long burst that saturates a narrowed frame counter.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int NUM_FC      = 29;
  localparam int NUM_BINS    = 7;
  localparam int RX_FLAGS    = 8;
  localparam int TX_FLAGS    = 4;
  localparam int RX_TOTAL    = 0;
  localparam int RX_FLAG0    = 1;
  localparam int RX_MAXLEN   = 9;
  localparam int RX_BIN0     = 10;
  localparam int TX_TOTAL    = 17;
  localparam int TX_FLAG0    = 18;
  localparam int TX_BIN0     = 22;
  localparam int A_RXB_LO    = 32;
  localparam int A_RXB_HI    = 33;
  localparam int A_TXB_LO    = 34;
  localparam int A_TXB_HI    = 35;
  localparam int ADDR_W      = 6;
  localparam int RD_W        = 32;

  // length bin index, shared by both directions
  function automatic logic [2:0] size_bin(input logic [31:0] len);
    if (len <= 32'd64)        return 3'd0;
    else if (len <= 32'd127)  return 3'd1;
    else if (len <= 32'd255)  return 3'd2;
    else if (len <= 32'd511)  return 3'd3;
    else if (len <= 32'd1023) return 3'd4;
    else if (len <= 32'd1518) return 3'd5;
    else                      return 3'd6;
  endfunction
endpackage

// File: rtl/stats_event_decode.sv
module stats_event_decode
  import stats_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic              ev_valid,
  input  logic              ev_dir,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic [7:0]        ev_flags,
  input  logic [LEN_W-1:0]  cfg_max_len,
  output logic [NUM_FC-1:0] fc_inc,
  output logic              rxb_inc,
  output logic              txb_inc
);
  logic       is_rx;
  logic       is_tx;
  logic [2:0] bin;

  assign is_rx   = ev_valid & ~ev_dir;
  assign is_tx   = ev_valid & ev_dir;
  assign bin     = size_bin(32'(ev_len));
  assign rxb_inc = is_rx;
  assign txb_inc = is_tx;

  assign fc_inc[RX_TOTAL]  = is_rx;
  assign fc_inc[RX_MAXLEN] = is_rx & (ev_len > cfg_max_len);
  assign fc_inc[TX_TOTAL]  = is_tx;

  for (genvar f = 0; f < RX_FLAGS; f++) begin : g_rx_flag
    assign fc_inc[RX_FLAG0+f] = is_rx & ev_flags[f];
  end

  for (genvar f = 0; f < TX_FLAGS; f++) begin : g_tx_flag
    assign fc_inc[TX_FLAG0+f] = is_tx & ev_flags[f];
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign fc_inc[RX_BIN0+b] = is_rx & (bin == 3'(b));
    assign fc_inc[TX_BIN0+b] = is_tx & (bin == 3'(b));
  end
endmodule

// File: rtl/stats_sat_counter.sv
module stats_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_amt,
  output logic [W-1:0]     cnt
);
  localparam int PAD = W - INC_W;

  logic [W-1:0] add;
  logic [W:0]   sum;
  logic [W-1:0] sat;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    add     = {{PAD{1'b0}}, inc_amt};
    sum     = {1'b0, cnt} + {1'b0, add};
    sat     = sum[W] ? '1 : sum[W-1:0];
    cnt_en  = clr | inc_en;
    if (clr) cnt_nxt = inc_en ? add : '0;
    else     cnt_nxt = sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/stats_read_port.sv
module stats_read_port
  import stats_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BYTE_W  = 45
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           clr_all,
  input  logic [NUM_FC-1:0][FRAME_W-1:0] frame_cnt,
  input  logic [BYTE_W-1:0]              rx_bytes,
  input  logic [BYTE_W-1:0]              tx_bytes,
  output logic [NUM_FC-1:0]              fc_clr,
  output logic                           rxb_clr,
  output logic                           txb_clr,
  output logic                           rd_valid,
  output logic [RD_W-1:0]                rd_data
);
  localparam int HI_W = BYTE_W - RD_W;

  logic [RD_W-1:0] sel_data;
  logic [RD_W-1:0] data_nxt;
  logic [HI_W-1:0] sh_rx, sh_tx, sh_rx_nxt, sh_tx_nxt;
  logic            ld_rx, ld_tx, sh_en;

  always_comb begin
    sel_data = '0;
    fc_clr   = '0;
    rxb_clr  = 1'b0;
    txb_clr  = 1'b0;
    ld_rx    = 1'b0;
    ld_tx    = 1'b0;
    for (int i = 0; i < NUM_FC; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        sel_data[FRAME_W-1:0] = frame_cnt[i];
        fc_clr[i]             = rd_en;
      end
    end
    case (rd_addr)
      ADDR_W'(A_RXB_LO): begin
        sel_data = rx_bytes[RD_W-1:0];
        rxb_clr  = rd_en;
        ld_rx    = rd_en;
      end
      ADDR_W'(A_RXB_HI): sel_data[HI_W-1:0] = sh_rx;
      ADDR_W'(A_TXB_LO): begin
        sel_data = tx_bytes[RD_W-1:0];
        txb_clr  = rd_en;
        ld_tx    = rd_en;
      end
      ADDR_W'(A_TXB_HI): sel_data[HI_W-1:0] = sh_tx;
      default: ;
    endcase
    data_nxt  = rd_en ? sel_data : rd_data;
    sh_en     = clr_all | ld_rx | ld_tx;
    sh_rx_nxt = clr_all ? '0 : (ld_rx ? rx_bytes[BYTE_W-1:RD_W] : sh_rx);
    sh_tx_nxt = clr_all ? '0 : (ld_tx ? tx_bytes[BYTE_W-1:RD_W] : sh_tx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= data_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rx <= '0;
      sh_tx <= '0;
    end else if (sh_en) begin
      sh_rx <= sh_rx_nxt;
      sh_tx <= sh_tx_nxt;
    end
  end
endmodule

// File: rtl/stats_bank.sv
module stats_bank
  import stats_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BYTE_W  = 45,
  parameter int LEN_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_dir,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic [7:0]        ev_flags,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              clr_all,
  input  logic              rd_en,
  input  logic [5:0]        rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  logic                           rst_m, rst_q;
  logic [NUM_FC-1:0]              fc_inc, fc_clr;
  logic [NUM_FC-1:0][FRAME_W-1:0] frame_cnt;
  logic                           rxb_inc, txb_inc, rxb_clr, txb_clr;
  logic [BYTE_W-1:0]              rx_bytes, tx_bytes;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  stats_event_decode #(.LEN_W(LEN_W)) u_dec (
    .ev_valid    (ev_valid),
    .ev_dir      (ev_dir),
    .ev_len      (ev_len),
    .ev_flags    (ev_flags),
    .cfg_max_len (cfg_max_len),
    .fc_inc      (fc_inc),
    .rxb_inc     (rxb_inc),
    .txb_inc     (txb_inc)
  );

  for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
    stats_sat_counter #(.W(FRAME_W), .INC_W(1)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_q),
      .clr     (fc_clr[g] | clr_all),
      .inc_en  (fc_inc[g]),
      .inc_amt (1'b1),
      .cnt     (frame_cnt[g])
    );
  end

  stats_sat_counter #(.W(BYTE_W), .INC_W(LEN_W)) u_rxb (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (rxb_clr | clr_all),
    .inc_en  (rxb_inc),
    .inc_amt (ev_len),
    .cnt     (rx_bytes)
  );

  stats_sat_counter #(.W(BYTE_W), .INC_W(LEN_W)) u_txb (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (txb_clr | clr_all),
    .inc_en  (txb_inc),
    .inc_amt (ev_len),
    .cnt     (tx_bytes)
  );

  stats_read_port #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .clr_all   (clr_all),
    .frame_cnt (frame_cnt),
    .rx_bytes  (rx_bytes),
    .tx_bytes  (tx_bytes),
    .fc_clr    (fc_clr),
    .rxb_clr   (rxb_clr),
    .txb_clr   (txb_clr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk
  import stats_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_valid,
  input logic               ev_dir,
  input logic               clr_all,
  input logic               rd_en,
  input logic [5:0]         rd_addr,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic [FRAME_W-1:0] tot
);
  localparam logic [FRAME_W-1:0] TOT_MAX = '1;

  logic tot_rd;
  logic unmapped;
  assign tot_rd   = rd_en && (rd_addr == 6'(RX_TOTAL));
  assign unmapped = (rd_addr >= 6'(NUM_FC) && rd_addr < 6'(A_RXB_LO)) || rd_addr > 6'(A_TXB_HI);

  // R10
  rdv_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R10
  rdv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> rd_data == 32'd0);
  // R1
  rx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_dir && !clr_all && !tot_rd && tot != TOT_MAX) |=> tot == $past(tot) + 1'b1);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clr_all && !tot_rd) |=> $stable(tot));
  // R7
  fresh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_rd && ev_valid && !ev_dir) |=> tot == FRAME_W'(1));
  // R8
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !ev_valid) |=> tot == '0);
  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tot == TOT_MAX && !clr_all && !tot_rd) |=> tot == TOT_MAX);
endmodule

bind stats_bank stats_bank_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .ev_valid (ev_valid),
  .ev_dir   (ev_dir),
  .clr_all  (clr_all),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .tot      (frame_cnt[0])
);

// File: tb/test_stats_bank.sv
module test_stats_bank;
  localparam int FW = 10;
  localparam int BW = 45;
  localparam int LW = 24;
  localparam longint FMAX = (64'd1 << FW) - 1;
  localparam longint BMAX = (64'd1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0, ev_dir = 1'b0, clr_all = 1'b0, rd_en = 1'b0;
  logic [LW-1:0] ev_len = '0, cfg_max_len = LW'(1518);
  logic [7:0]    ev_flags = '0;
  logic [5:0]    rd_addr = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;

  int checks = 0, fails = 0;
  longint m_fc [29];
  longint m_rxb = 0, m_txb = 0, m_shrx = 0, m_shtx = 0;

  always #4 clk = ~clk;

  stats_bank #(.FRAME_W(FW), .BYTE_W(BW), .LEN_W(LW)) i_stats_bank (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dir(ev_dir), .ev_len(ev_len),
    .ev_flags(ev_flags), .cfg_max_len(cfg_max_len), .clr_all(clr_all), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic int bin_of(int len);
    if (len <= 64) return 0;
    if (len <= 127) return 1;
    if (len <= 255) return 2;
    if (len <= 511) return 3;
    if (len <= 1023) return 4;
    if (len <= 1518) return 5;
    return 6;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0 || (a >= 10 && a <= 16)) return "R1";
    if (a >= 1 && a <= 8) return "R2";
    if (a == 9) return "R3";
    if (a >= 17 && a <= 28) return "R4";
    if (a >= 32 && a <= 35) return "R5";
    return "R10";
  endfunction

  function automatic int edge_len(int k);
    case (k % 13)
      0: return 63;   1: return 64;   2: return 65;   3: return 127;
      4: return 128;  5: return 255;  6: return 256;  7: return 511;
      8: return 512;  9: return 1023; 10: return 1024; 11: return 1518;
      default: return 1519;
    endcase
  endfunction

  function automatic void bump(int i);
    if (m_fc[i] < FMAX) m_fc[i]++;
  endfunction

  function automatic void model_event(bit dir, int len, bit [7:0] fl);
    if (!dir) begin
      bump(0);
      for (int i = 0; i < 8; i++) if (fl[i]) bump(1 + i);
      if (len > int'(cfg_max_len)) bump(9);
      bump(10 + bin_of(len));
      m_rxb = (m_rxb + len > BMAX) ? BMAX : m_rxb + len;
    end else begin
      bump(17);
      for (int i = 0; i < 4; i++) if (fl[i]) bump(18 + i);
      bump(22 + bin_of(len));
      m_txb = (m_txb + len > BMAX) ? BMAX : m_txb + len;
    end
  endfunction

  function automatic longint model_read(int a);
    longint v = 0;
    if (a < 29) begin v = m_fc[a]; m_fc[a] = 0; end
    else if (a == 32) begin v = m_rxb & 64'hFFFF_FFFF; m_shrx = m_rxb >> 32; m_rxb = 0; end
    else if (a == 33) v = m_shrx;
    else if (a == 34) begin v = m_txb & 64'hFFFF_FFFF; m_shtx = m_txb >> 32; m_txb = 0; end
    else if (a == 35) v = m_shtx;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, check read data after the next rising edge
  task automatic cyc(bit ev, bit dir, int len, bit [7:0] fl, bit rd, int a, bit clr, string tag);
    longint exp = 0;
    ev_valid = ev; ev_dir = dir; ev_len = LW'(len); ev_flags = fl;
    rd_en = rd; rd_addr = 6'(a); clr_all = clr;
    if (rd) exp = model_read(a);
    if (clr) begin
      foreach (m_fc[i]) m_fc[i] = 0;
      m_rxb = 0; m_txb = 0; m_shrx = 0; m_shtx = 0;
    end
    if (ev) model_event(dir, len, fl);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0; clr_all = 1'b0;
    if (rd) begin
      check("R10", longint'(rd_valid), 1, "rd_valid");
      check((tag == "") ? tag_of(a) : tag, longint'(rd_data), exp, $sformatf("addr=%0d", a));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(1234));
    foreach (m_fc[i]) m_fc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", longint'(rd_valid), 0, "rd_valid after reset");
    for (int a = 0; a < 36; a++) cyc(0, 0, 0, 0, 1, a, 0, "R11");
    // R1: bin edges
    for (int k = 0; k < 13; k++) cyc(1, 0, edge_len(k), 8'h00, 0, 0, 0, "");
    for (int a = 10; a <= 16; a++) cyc(0, 0, 0, 0, 1, a, 0, "R1");
    // R2 and R4: flag mapping, tx ignores upper flags
    cyc(1, 0, 100, 8'hA5, 0, 0, 0, "");
    cyc(1, 1, 100, 8'hF6, 0, 0, 0, "");
    for (int a = 0; a <= 28; a++) cyc(0, 0, 0, 0, 1, a, 0, "");
    // R7: read coinciding with an event
    cyc(1, 0, 70, 0, 0, 0, 0, "");
    cyc(1, 0, 70, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 0, 0, "R7");
    // R8: clear-all coinciding with a tx event
    cyc(1, 0, 300, 8'hFF, 0, 0, 0, "");
    cyc(1, 1, 300, 8'h01, 0, 0, 1, "");
    for (int a = 0; a < 36; a++) cyc(0, 0, 0, 0, 1, a, 0, "R8");
    // R3: one below and one above a lowered limit
    cfg_max_len = LW'(100);
    cyc(1, 0, 100, 0, 0, 0, 0, "");
    cyc(1, 0, 101, 0, 0, 0, 0, "");
    cyc(1, 1, 5000, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 9, 0, "R3");
    cfg_max_len = LW'(1518);
    // R5: fill the upper word; high word reads do not clear
    for (int i = 0; i < 300; i++) cyc(1, 1, 16000000, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 35, 0, "R5");
    cyc(0, 0, 0, 0, 1, 34, 0, "R5");
    cyc(0, 0, 0, 0, 1, 35, 0, "R5");
    cyc(0, 0, 0, 0, 1, 35, 0, "R6");
    cyc(0, 0, 0, 0, 1, 34, 0, "R6");
    // R9: saturation of the narrowed frame counter
    for (int i = 0; i < 1100; i++) cyc(1, 0, 64, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, 10, 0, "R9");
    // R10: unmapped addresses
    cyc(0, 0, 0, 0, 1, 29, 0, "R10");
    cyc(0, 0, 0, 0, 1, 31, 0, "R10");
    cyc(0, 0, 0, 0, 1, 36, 0, "R10");
    cyc(0, 0, 0, 0, 1, 63, 0, "R10");
    // random traffic
    for (int it = 0; it < 6000; it++) begin
      int len;
      if (it % 700 == 0) cfg_max_len = LW'(200 + $urandom % 1600);
      len = ($urandom % 4 == 0) ? edge_len($urandom % 13) : 1 + int'($urandom % 20000);
      cyc($urandom % 4 != 0, $urandom % 2, len, 8'($urandom), $urandom % 4 == 0,
          int'($urandom % 40), $urandom % 600 == 0, "");
    end
    for (int a = 0; a < 36; a++) cyc(0, 0, 0, 0, 1, a, 0, "");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule